// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers interrupt requests from a set of on-chip peripheral sources and from two external request pins, and presents one normal interrupt line and one fast interrupt line to a processor. Each normal source carries its own enable bit, a 3-bit priority level (0 lowest, 7 highest), a trigger mode and a 16-bit vector. The highest-priority source that is both requesting and enabled is the current winner. Its vector appears on `cur_vec_o` at all times.

Servicing runs through a small register port. Software reads the vector register to acknowledge the winner. The read returns the winner's vector, clears the winner's latched edge, and records the winner's level on a stack of active levels. While that stack holds a level, only a strictly higher level can raise the normal interrupt line again. A write to the end-of-interrupt register releases the most recent level.

The fast interrupt line follows a dedicated external pin only, through its own enable. Internal sources are numbered 0 to NUM_INT-1. The external request pins follow as sources NUM_INT and NUM_INT+1.

Top module: `prio_vic`

## Requirements
- R1: After reset, `irq_o` and `fiq_o` are low, all source enables (address 0) and the fast enable (address 1) read 0, and every source configuration word reads 0.
- R2: A source whose enable bit i at address 0 is 0 never becomes the winner and never asserts `irq_o`, while still showing in the request register.
- R3: The configuration word of source i is at address 8+i: priority in bits [2:0], trigger mode in bits [5:4], vector in bits [31:16]. It reads back as written in those fields. Among enabled requesting sources the highest priority wins and its vector drives `cur_vec_o`.
- R4: Among winners of equal priority, the lowest source number is selected.
- R5: For internal sources, mode bit 4 selects a rising-edge latch (1) or an active-high level (0). Mode bit 5 has no effect.
- R6: External sources pass two synchronizing flip-flops. Their mode values are 0 high level, 1 rising edge, 2 low level and 3 falling edge, and an edge of the other direction is not latched.
- R7: An edge request stays pending until the vector read that selects it. A level request follows its input and is not cleared by a vector read.
- R8: Reading address 2 while `irq_o` is high returns the winner's vector in bits [15:0] and pushes its level. While `irq_o` is low it returns 0 and pushes nothing.
- R9: While the level stack is not empty, `irq_o` is high only when the winner's priority is strictly above the top stacked level.
- R10: Writing address 3 pops the top stacked level. On an empty stack the write has no effect.
- R11: `fiq_o` equals the synchronized fast pin ANDed with bit 0 of address 1. No normal source affects it.
- R12: Address 4 returns the raw request bit of every source, one bit per source number, regardless of enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| int_src_i | input | NUM_INT | Internal peripheral request lines, synchronous to clk_i |
| ext_irq_i | input | NUM_EXT | External request pins, asynchronous |
| ext_fiq_i | input | 1 | External fast request pin, active high, asynchronous |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | ADDR_W | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid in the cycle reg_rd_i is high |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| cur_vec_o | output | 16 | Vector of the current winner, 0 when none |

## Verification
The assertions assume that a vector read and an end-of-interrupt write do not occur in the same cycle. They also assume internal request lines change only right after a clock edge. The bench drives every strobe and input shortly after the rising edge, issues one register access per transfer, and never overlaps an acknowledge with a pop. External pins are held steady for at least four cycles, so each level or edge passes the synchronizers before it is checked. The stack assertions also rely on priorities staying within 0 to 7, which the 3-bit field guarantees.

// File: rtl/pvic_pkg.sv
package pvic_pkg;
  localparam int DATA_W  = 32;
  localparam int PRIO_W  = 3;
  localparam int NUM_LVL = 1 << PRIO_W;
  localparam int VEC_W   = 16;

  localparam int ADR_MASK = 0;
  localparam int ADR_FIQ  = 1;
  localparam int ADR_VEC  = 2;
  localparam int ADR_EOI  = 3;
  localparam int ADR_PEND = 4;
  localparam int ADR_CFG0 = 8;

  typedef enum logic [1:0] {
    TRIG_HIGH = 2'd0,
    TRIG_RISE = 2'd1,
    TRIG_LOW  = 2'd2,
    TRIG_FALL = 2'd3
  } trig_e;

  typedef struct packed {
    logic [VEC_W-1:0]  vec;
    trig_e             mode;
    logic [PRIO_W-1:0] prio;
  } src_cfg_t;
endpackage

// File: rtl/pvic_src_cond.sv
module pvic_src_cond
  import pvic_pkg::*;
#(
  parameter bit EXT = 1'b0
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  raw_i,
  input  trig_e mode_i,
  input  logic  clr_i,
  output logic  req_o
);
  logic sig, prev_q, pend_q;

  if (EXT) begin : g_sync
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
      end else begin
        s1_q <= raw_i;
        s2_q <= s1_q;
      end
    end
    assign sig = s2_q;
  end else begin : g_direct
    assign sig = raw_i;
  end

  // polarity select exists only on external pins
  logic pol_low, is_edge, lvl_act, edge_hit;
  assign pol_low  = EXT && mode_i[1];
  assign is_edge  = mode_i[0];
  assign lvl_act  = pol_low ? ~sig : sig;
  assign edge_hit = pol_low ? (~sig & prev_q) : (sig & ~prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      prev_q <= sig;
      if (is_edge && edge_hit) pend_q <= 1'b1;
      else if (clr_i || !is_edge) pend_q <= 1'b0;
    end
  end

  assign req_o = is_edge ? pend_q : lvl_act;
endmodule

// File: rtl/pvic_arbiter.sv
module pvic_arbiter
  import pvic_pkg::*;
#(
  parameter int N     = 6,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N-1:0]               elig_i,
  input  logic [N-1:0][PRIO_W-1:0]   prio_i,
  output logic                       valid_o,
  output logic [IDX_W-1:0]           idx_o,
  output logic [PRIO_W-1:0]          prio_o
);
  // strict compare keeps the lowest index on a tie
  always_comb begin
    valid_o = 1'b0;
    idx_o   = '0;
    prio_o  = '0;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i] && (!valid_o || prio_i[i] > prio_o)) begin
        valid_o = 1'b1;
        idx_o   = IDX_W'(i);
        prio_o  = prio_i[i];
      end
    end
  end

  // R3
  win_is_elig_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> elig_i[idx_o]);
endmodule

// File: rtl/pvic_lvl_stack.sv
module pvic_lvl_stack
  import pvic_pkg::*;
#(
  parameter int DEPTH = NUM_LVL,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [PRIO_W-1:0] lvl_i,
  output logic              empty_o,
  output logic [PRIO_W-1:0] top_o,
  output logic [CNT_W-1:0]  depth_o
);
  logic [PRIO_W-1:0] mem_q [DEPTH];
  logic [CNT_W-1:0]  cnt_q;
  logic [PTR_W-1:0]  top_ptr, nxt_ptr;

  assign top_ptr = PTR_W'(cnt_q - 1'b1);
  assign nxt_ptr = PTR_W'(cnt_q);
  assign empty_o = (cnt_q == '0);
  assign top_o   = empty_o ? '0 : mem_q[top_ptr];
  assign depth_o = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push_i && pop_i && !empty_o) begin
      mem_q[top_ptr] <= lvl_i;
    end else if (push_i) begin
      mem_q[nxt_ptr] <= lvl_i;
      cnt_q          <= cnt_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> (cnt_q < CNT_W'(DEPTH)));

  // R9
  lvl_rising_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i && !empty_o) |=> (top_o > $past(top_o)));
endmodule

// File: rtl/prio_vic.sv
module prio_vic
  import pvic_pkg::*;
#(
  parameter int NUM_INT = 4,
  parameter int NUM_EXT = 2,
  parameter int ADDR_W  = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_INT-1:0] int_src_i,
  input  logic [NUM_EXT-1:0] ext_irq_i,
  input  logic               ext_fiq_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               irq_o,
  output logic               fiq_o,
  output logic [15:0]        cur_vec_o
);
  localparam int NUM_SRC = NUM_INT + NUM_EXT;
  localparam int IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int CNT_W   = $clog2(NUM_LVL + 1);

  logic [NUM_SRC-1:0]             raw, req, elig, clr, mask_q;
  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_vec;
  src_cfg_t                       cfg_q [NUM_SRC];
  logic                           fiq_en_q, fiq_s1_q, fiq_s2_q;

  logic              win_valid;
  logic [IDX_W-1:0]  win_idx;
  logic [PRIO_W-1:0] win_prio;
  logic              stk_empty;
  logic [PRIO_W-1:0] stk_top;
  logic [CNT_W-1:0]  stk_depth;
  logic              ack, ack_ok, eoi;

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i[15:6];

  assign raw  = {ext_irq_i, int_src_i};
  assign elig = req & mask_q;

  assign ack    = reg_rd_i && (reg_addr_i == ADDR_W'(ADR_VEC));
  assign eoi    = reg_wr_i && (reg_addr_i == ADDR_W'(ADR_EOI));
  assign ack_ok = ack && irq_o;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign prio_vec[i] = cfg_q[i].prio;
    assign clr[i]      = ack_ok && (win_idx == IDX_W'(i));

    pvic_src_cond #(.EXT(i >= NUM_INT)) u_cond (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw[i]),
      .mode_i (cfg_q[i].mode),
      .clr_i  (clr[i]),
      .req_o  (req[i])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[i] <= '0;
      end else if (reg_wr_i && reg_addr_i == ADDR_W'(ADR_CFG0 + i)) begin
        cfg_q[i].prio <= reg_wdata_i[2:0];
        cfg_q[i].mode <= trig_e'(reg_wdata_i[5:4]);
        cfg_q[i].vec  <= reg_wdata_i[31:16];
      end
    end
  end

  pvic_arbiter #(.N(NUM_SRC)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .elig_i  (elig),
    .prio_i  (prio_vec),
    .valid_o (win_valid),
    .idx_o   (win_idx),
    .prio_o  (win_prio)
  );

  pvic_lvl_stack #(.DEPTH(NUM_LVL)) u_stk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (ack_ok),
    .pop_i   (eoi),
    .lvl_i   (win_prio),
    .empty_o (stk_empty),
    .top_o   (stk_top),
    .depth_o (stk_depth)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q   <= '0;
      fiq_en_q <= 1'b0;
      fiq_s1_q <= 1'b0;
      fiq_s2_q <= 1'b0;
    end else begin
      fiq_s1_q <= ext_fiq_i;
      fiq_s2_q <= fiq_s1_q;
      if (reg_wr_i && reg_addr_i == ADDR_W'(ADR_MASK)) mask_q <= reg_wdata_i[NUM_SRC-1:0];
      if (reg_wr_i && reg_addr_i == ADDR_W'(ADR_FIQ))  fiq_en_q <= reg_wdata_i[0];
    end
  end

  assign irq_o     = win_valid && (stk_empty || win_prio > stk_top);
  assign fiq_o     = fiq_s2_q && fiq_en_q;
  assign cur_vec_o = win_valid ? cfg_q[win_idx].vec : '0;

  always_comb begin
    reg_rdata_o = '0;
    if (reg_rd_i) begin
      if (reg_addr_i == ADDR_W'(ADR_MASK))      reg_rdata_o = DATA_W'(mask_q);
      else if (reg_addr_i == ADDR_W'(ADR_FIQ))  reg_rdata_o = DATA_W'(fiq_en_q);
      else if (reg_addr_i == ADDR_W'(ADR_VEC))  reg_rdata_o = irq_o ? DATA_W'(cur_vec_o) : '0;
      else if (reg_addr_i == ADDR_W'(ADR_PEND)) reg_rdata_o = DATA_W'(req);
      for (int i = 0; i < NUM_SRC; i++) begin
        if (reg_addr_i == ADDR_W'(ADR_CFG0 + i))
          reg_rdata_o = {cfg_q[i].vec, 10'b0, cfg_q[i].mode, 1'b0, cfg_q[i].prio};
      end
    end
  end

  // R2
  irq_enabled_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> mask_q[win_idx]);

  // R8
  ack_push_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack && irq_o && !eoi) |=> (stk_depth == $past(stk_depth) + 1'b1));

  // R10
  eoi_pop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eoi && !ack && !stk_empty) |=> (stk_depth == $past(stk_depth) - 1'b1));
endmodule

// File: tb/prio_vic_tb_top.sv
module prio_vic_tb_top;
  localparam int ADDR_W = 5;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  int_src_i = '0;
  logic [1:0]  ext_irq_i = 2'b11;
  logic        ext_fiq_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic [ADDR_W-1:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        irq_o, fiq_o;
  logic [15:0] cur_vec_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #2 clk_i = ~clk_i;

  prio_vic #(.NUM_INT(4), .NUM_EXT(2), .ADDR_W(ADDR_W)) dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .int_src_i(int_src_i), .ext_irq_i(ext_irq_i),
    .ext_fiq_i(ext_fiq_i), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_addr_i(reg_addr_i), .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
    .irq_o(irq_o), .fiq_o(fiq_o), .cur_vec_o(cur_vec_o)
  );

  // monitor: pops expected read data as each read completes
  always @(negedge clk_i) begin
    if (reg_rd_i) begin
      exp_t e;
      checks++;
      if (sb_q.size() == 0) begin
        errors++;
        $display("FAIL scoreboard: read with no expected item, actual %h", reg_rdata_o);
      end else begin
        e = sb_q.pop_front();
        if (reg_rdata_o !== e.exp) begin
          errors++;
          $display("FAIL %s: actual %h expected %h", e.tag, reg_rdata_o, e.exp);
        end
      end
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  task automatic reg_write(input int adr, input logic [31:0] data);
    @(posedge clk_i); #1;
    reg_wr_i = 1'b1; reg_addr_i = ADDR_W'(adr); reg_wdata_i = data;
    @(posedge clk_i); #1;
    reg_wr_i = 1'b0;
  endtask

  task automatic reg_read(input int adr, input logic [31:0] exp, input string tag);
    exp_t e;
    @(posedge clk_i); #1;
    reg_rd_i = 1'b1; reg_addr_i = ADDR_W'(adr);
    e.exp = exp; e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk_i); #1;
    reg_rd_i = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag, input logic irq_e, input logic [15:0] vec_e);
    @(negedge clk_i);
    chk({tag, " irq"}, {31'b0, irq_o}, {31'b0, irq_e});
    chk({tag, " vec"}, {16'b0, cur_vec_o}, {16'b0, vec_e});
  endtask

  task automatic chk_fiq(input string tag, input logic exp);
    @(negedge clk_i);
    chk(tag, {31'b0, fiq_o}, {31'b0, exp});
  endtask

  function automatic logic [31:0] cfgw(input int prio, input int mode, input int vec);
    return {vec[15:0], 10'b0, mode[1:0], 1'b0, prio[2:0]};
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    wait_cyc(3);
    rst_ni = 1'b1;
    // R1 reset state
    chk_out("R1 reset", 1'b0, 16'h0);
    chk_fiq("R1 reset fiq", 1'b0);
    reg_read(0, 32'h0, "R1 enable reg");
    reg_read(1, 32'h0, "R1 fiq enable reg");
    reg_read(11, 32'h0, "R1 cfg src3");

    reg_write(8,  cfgw(2, 0, 16'h100));
    reg_write(9,  cfgw(5, 1, 16'h101));
    reg_write(10, cfgw(5, 0, 16'h102));
    reg_write(11, cfgw(2, 2, 16'h103));
    reg_write(12, cfgw(6, 3, 16'h104));
    reg_write(13, cfgw(3, 2, 16'h105));
    reg_read(9, cfgw(5, 1, 16'h101), "R3 cfg readback");

    int_src_i[0] = 1'b1;
    wait_cyc(3);
    chk_out("R2 masked source", 1'b0, 16'h0);
    reg_read(4, 32'h01, "R12 raw requests ignore enables");

    reg_write(0, 32'h3F);
    chk_out("R3 single winner", 1'b1, 16'h100);
    int_src_i[2] = 1'b1;
    wait_cyc(2);
    chk_out("R3 higher level wins", 1'b1, 16'h102);

    int_src_i[1] = 1'b1; wait_cyc(1); int_src_i[1] = 1'b0;
    wait_cyc(2);
    chk_out("R4 tie lower index", 1'b1, 16'h101);
    reg_read(4, 32'h07, "R7 edge latched");

    reg_read(2, 32'h101, "R8 ack vector");
    chk_out("R9 equal level blocked", 1'b0, 16'h102);
    reg_read(4, 32'h05, "R7 edge cleared by ack");

    ext_irq_i[0] = 1'b0;
    wait_cyc(5);
    chk_out("R6 falling edge preempts", 1'b1, 16'h104);
    reg_read(2, 32'h104, "R8 nested ack");
    chk_out("R9 after nested ack", 1'b0, 16'h102);

    reg_write(3, 32'h0);
    chk_out("R10 first pop keeps level 5", 1'b0, 16'h102);
    reg_write(3, 32'h0);
    chk_out("R10 second pop frees", 1'b1, 16'h102);
    reg_read(2, 32'h102, "R8 ack level source");
    reg_read(4, 32'h05, "R7 level stays after ack");
    int_src_i[2] = 1'b0;
    reg_write(3, 32'h0);
    chk_out("R3 fallback winner", 1'b1, 16'h100);

    ext_irq_i[0] = 1'b1;
    wait_cyc(5);
    reg_read(4, 32'h01, "R6 rising edge not latched in falling mode");

    int_src_i[3] = 1'b1;
    wait_cyc(1);
    reg_read(4, 32'h09, "R5 internal mode bit5 ignored");
    chk_out("R4 tie keeps src0", 1'b1, 16'h100);

    ext_irq_i[1] = 1'b0;
    wait_cyc(4);
    chk_out("R6 low level", 1'b1, 16'h105);
    ext_irq_i[1] = 1'b1;
    wait_cyc(4);
    chk_out("R6 low level released", 1'b1, 16'h100);

    reg_write(0, 32'h3E);
    chk_out("R2 disable src0", 1'b1, 16'h103);

    int_src_i[0] = 1'b0; int_src_i[3] = 1'b0;
    wait_cyc(2);
    chk_out("R8 idle", 1'b0, 16'h0);
    reg_read(2, 32'h0, "R8 spurious read");
    reg_write(3, 32'h0);
    int_src_i[1] = 1'b1; wait_cyc(1); int_src_i[1] = 1'b0;
    wait_cyc(2);
    chk_out("R10 empty pop ignored", 1'b1, 16'h101);

    ext_fiq_i = 1'b1;
    wait_cyc(4);
    chk_fiq("R11 fast masked", 1'b0);
    reg_write(1, 32'h1);
    chk_fiq("R11 fast enabled", 1'b1);
    reg_read(2, 32'h101, "R8 ack during fast");
    chk_out("R11 normal line independent", 1'b0, 16'h0);
    reg_write(3, 32'h0);
    reg_write(0, 32'h3F);
    ext_fiq_i = 1'b0;
    int_src_i[0] = 1'b1;
    wait_cyc(4);
    chk_fiq("R11 peripherals do not drive fast", 1'b0);
    chk_out("R11 normal active", 1'b1, 16'h100);

    wait_cyc(2);
    if (sb_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
    end
    finish_run();
  end
endmodule